// File: doc/BRIEF.md
# Read-After-Write Stress Generator

This block drives a memory under test with pseudo-random traffic that is rich in read-during-write collisions, records what the memory returns, and checks that record against a second memory fed with the identical stimulus. It is meant to sit next to a bypassed memory, or a memory that forwards writes to reads, and a reference memory with the same initial contents. The memory write and read ports are driven on every cycle. There are no clock enables.

The block runs in loops. A loop has two phases, each `TRACE_LEN` cycles long. In the capture phase, the stimulus goes to the memory under test and the returned read data is stored in a trace buffer. In the replay phase, the same stimulus is regenerated and routed to the reference memory, and each returned word is compared with the stored one. Any difference raises a sticky error flag. After the replay, the address generator takes a fresh seed from a second, smaller LFSR, and the next loop starts.

Addresses come from a 16-bit LFSR. Its upper byte is the write address and its lower byte is the normal read address. A fixed 3-bit pattern in its low bits forces the read address onto the write address, about one cycle in eight. Write data comes from a separate 16-bit LFSR that restarts at a fixed seed at the start of every phase.

Top module: `raw_stress_top`

## Requirements
- R1: The address LFSR is 16 bits. It shifts left and inserts the XOR of bits 15, 13, 12 and 10 at bit 0. It advances one step on every cycle that is not the last cycle of a phase. `wr_addr_o` is its bits [15:8] and the unforced `rd_addr_o` is its bits [7:0].
- R2: When bits [2:0] of the address LFSR equal 3'b101, `rd_addr_o` equals `wr_addr_o` in that same cycle.
- R3: `wr_data_o` is a 16-bit LFSR. It shifts left and inserts the XOR of bits 15, 14, 12 and 3. It holds `DATA_SEED` in the first cycle of every phase and advances one step per cycle within the phase.
- R4: A phase lasts `TRACE_LEN` cycles. `ref_phase_o` is 0 during capture and 1 during replay, and the two phases alternate. The replay phase reproduces, cycle for cycle, the addresses and data of the capture phase that precedes it.
- R5: The seed LFSR is 8 bits. It shifts left and inserts the XOR of bits 7, 5, 4 and 3. At the end of a replay phase, the address LFSR is loaded with {s, s}, where s is the seed LFSR's current value, and the seed LFSR then advances one step. Out of reset, the address LFSR holds {S0, S0} and the seed LFSR holds one step past S0.
- R6: The word on `rd_data_i` in the cycle after a capture-phase cycle is stored as the trace entry for that cycle's position in the phase.
- R7: If the word on `rd_data_i` in the cycle after a replay-phase cycle differs from the stored entry for the same position, `err_o` is 1 from the following cycle onward. Matching data never sets it.
- R8: `err_o` stays 1 once set, whatever the later data, until a reset clears it to 0.
- R9: In reset, and in the first cycle after it, `ref_phase_o` is 0, `wr_addr_o` is S0, `wr_data_o` is `DATA_SEED` and `err_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_addr_o | output | 8 | Write address, written every cycle |
| wr_data_o | output | 16 | Write data |
| rd_addr_o | output | 8 | Read address, read every cycle |
| ref_phase_o | output | 1 | 0: traffic goes to the memory under test; 1: traffic goes to the reference memory |
| rd_data_i | input | 16 | Read data from the selected memory, one cycle after its address |
| err_o | output | 1 | Sticky mismatch flag |

## Verification
The embedded assertions check the following on every cycle:
- the phase counter stays in range;
- the phase flips exactly at the last cycle of a phase;
- the address LFSR never locks at zero;
- the capture-to-replay rewind and the end-of-loop reseed both happen;
- the data sequence restarts at each phase;
- the error flag stays set once raised and only rises after a replay comparison.

Only the bench's scenarios can show the rest:
- that the replayed stimulus really equals the captured stimulus;
- that forced collisions occur;
- that two identical memories never raise the flag;
- that a memory which returns stale data on a same-cycle collision does raise it, keeps it through clean traffic, and loses it only at reset.

// File: rtl/rsg_pkg.sv
package rsg_pkg;

    localparam int ADDR_W   = 8;
    localparam int PRI_W    = 2 * ADDR_W;
    localparam int SEED_W   = ADDR_W;
    localparam int DATA_W   = 16;
    localparam int FORCE_W  = 3;
    localparam logic [FORCE_W-1:0] FORCE_PAT = 3'b101;

    typedef enum logic {
        PH_CAPTURE = 1'b0,
        PH_REPLAY  = 1'b1
    } phase_e;

    function automatic logic [PRI_W-1:0] pri_step(input logic [PRI_W-1:0] s);
        return {s[PRI_W-2:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
    endfunction

    function automatic logic [SEED_W-1:0] seed_step(input logic [SEED_W-1:0] s);
        return {s[SEED_W-2:0], s[7] ^ s[5] ^ s[4] ^ s[3]};
    endfunction

    function automatic logic [DATA_W-1:0] data_step(input logic [DATA_W-1:0] s);
        return {s[DATA_W-2:0], s[15] ^ s[14] ^ s[12] ^ s[3]};
    endfunction

endpackage

// File: rtl/rsg_loop_ctl.sv
module rsg_loop_ctl
    import rsg_pkg::*;
#(
    parameter int TRACE_LEN = 256,
    localparam int IDX_W = (TRACE_LEN > 1) ? $clog2(TRACE_LEN) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    output logic             wrap_o,
    output phase_e           phase_o,
    output logic [IDX_W-1:0] idx_o
);

    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(TRACE_LEN - 1);

    typedef struct packed {
        logic [IDX_W-1:0] idx;
        phase_e           ph;
    } ctl_t;

    ctl_t st_d, st_q;
    logic at_last;

    always_comb begin
        st_d    = st_q;
        at_last = (st_q.idx == LAST_IDX);
        if (at_last) begin
            st_d.idx = '0;
            st_d.ph  = (st_q.ph == PH_CAPTURE) ? PH_REPLAY : PH_CAPTURE;
        end else begin
            st_d.idx = st_q.idx + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '{idx: '0, ph: PH_CAPTURE};
        end else begin
            st_q <= st_d;
        end
    end

    assign wrap_o  = at_last;
    assign phase_o = st_q.ph;
    assign idx_o   = st_q.idx;

    // R4: position within a phase stays inside the trace length
    p_idx_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
        32'(st_q.idx) < TRACE_LEN);

    // R4: phase flips exactly when a phase completes
    p_phase_flip_r4: assert property (@(posedge clk) disable iff (!rst_n)
        wrap_o |=> (phase_o != $past(phase_o)));

    p_phase_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !wrap_o |=> $stable(phase_o));

endmodule

// File: rtl/rsg_addr_gen.sv
module rsg_addr_gen
    import rsg_pkg::*;
#(
    parameter logic [SEED_W-1:0] S0 = 8'h5A
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wrap_i,
    input  phase_e            phase_i,
    output logic [ADDR_W-1:0] wr_addr_o,
    output logic [ADDR_W-1:0] rd_addr_o
);

    typedef struct packed {
        logic [PRI_W-1:0]  pri;
        logic [PRI_W-1:0]  base;
        logic [SEED_W-1:0] seed;
    } agen_t;

    agen_t st_d, st_q;
    logic  force_hit;

    always_comb begin
        st_d = st_q;
        if (wrap_i) begin
            if (phase_i == PH_CAPTURE) begin
                st_d.pri = st_q.base;
            end else begin
                st_d.pri  = {st_q.seed, st_q.seed};
                st_d.base = {st_q.seed, st_q.seed};
                st_d.seed = seed_step(st_q.seed);
            end
        end else begin
            st_d.pri = pri_step(st_q.pri);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '{pri: {S0, S0}, base: {S0, S0}, seed: seed_step(S0)};
        end else begin
            st_q <= st_d;
        end
    end

    assign force_hit = (st_q.pri[FORCE_W-1:0] == FORCE_PAT);
    assign wr_addr_o = st_q.pri[PRI_W-1:ADDR_W];
    assign rd_addr_o = force_hit ? st_q.pri[PRI_W-1:ADDR_W] : st_q.pri[ADDR_W-1:0];

    // R1: address sequence never falls into the all-zero lock state
    p_pri_nonzero_r1: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.pri != '0);

    // R4: replay starts from the same state as the capture it repeats
    p_rewind_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wrap_i && phase_i == PH_CAPTURE) |=> (st_q.pri == $past(st_q.base)));

    // R5: end of loop reloads from the seed LFSR
    p_reseed_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (wrap_i && phase_i == PH_REPLAY) |=> (st_q.pri == {$past(st_q.seed), $past(st_q.seed)}));

    // R5: seed LFSR moves only at the end of a loop
    p_seed_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !(wrap_i && phase_i == PH_REPLAY) |=> $stable(st_q.seed));

endmodule

// File: rtl/rsg_data_seq.sv
module rsg_data_seq
    import rsg_pkg::*;
#(
    parameter logic [DATA_W-1:0] DATA_SEED = 16'hACE1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wrap_i,
    output logic [DATA_W-1:0] data_o
);

    typedef struct packed {
        logic [DATA_W-1:0] val;
    } dseq_t;

    dseq_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wrap_i) begin
            st_d.val = DATA_SEED;
        end else begin
            st_d.val = data_step(st_q.val);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '{val: DATA_SEED};
        end else begin
            st_q <= st_d;
        end
    end

    assign data_o = st_q.val;

    // R3: each phase begins from the data seed
    p_restart_r3: assert property (@(posedge clk) disable iff (!rst_n)
        wrap_i |=> (data_o == DATA_SEED));

    p_nonzero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        data_o != '0);

endmodule

// File: rtl/rsg_trace_chk.sv
module rsg_trace_chk
    import rsg_pkg::*;
#(
    parameter int TRACE_LEN = 256,
    localparam int IDX_W = (TRACE_LEN > 1) ? $clog2(TRACE_LEN) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IDX_W-1:0]  idx_i,
    input  phase_e            phase_i,
    input  logic [DATA_W-1:0] rd_data_i,
    output logic              err_o
);

    typedef struct packed {
        logic             vld;
        phase_e           ph;
        logic [IDX_W-1:0] idx;
        logic             err;
    } chk_t;

    chk_t st_d, st_q;
    logic [DATA_W-1:0] trace_mem [TRACE_LEN];
    logic [DATA_W-1:0] stored;
    logic              cap_wr;
    logic              mismatch;

    always_comb begin
        stored   = trace_mem[st_q.idx];
        cap_wr   = st_q.vld && (st_q.ph == PH_CAPTURE);
        mismatch = st_q.vld && (st_q.ph == PH_REPLAY) && (rd_data_i != stored);
        st_d     = st_q;
        st_d.vld = 1'b1;
        st_d.ph  = phase_i;
        st_d.idx = idx_i;
        st_d.err = st_q.err | mismatch;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '{vld: 1'b0, ph: PH_CAPTURE, idx: '0, err: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    always_ff @(posedge clk) begin
        if (cap_wr) begin
            trace_mem[st_q.idx] <= rd_data_i;
        end
    end

    assign err_o = st_q.err;

    // R8: flag is sticky until reset
    p_err_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |=> err_o);

    // R7: flag only rises after a replay-phase comparison
    p_err_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_o) |-> ($past(st_q.vld) && $past(st_q.ph) == PH_REPLAY));

endmodule

// File: rtl/raw_stress_top.sv
module raw_stress_top
    import rsg_pkg::*;
#(
    parameter int                TRACE_LEN = 256,
    parameter logic [7:0]        S0        = 8'h5A,
    parameter logic [15:0]       DATA_SEED = 16'hACE1
) (
    input  logic        clk,
    input  logic        rst_n,
    output logic [7:0]  wr_addr_o,
    output logic [15:0] wr_data_o,
    output logic [7:0]  rd_addr_o,
    output logic        ref_phase_o,
    input  logic [15:0] rd_data_i,
    output logic        err_o
);

    localparam int IDX_W = (TRACE_LEN > 1) ? $clog2(TRACE_LEN) : 1;

    logic             wrap;
    phase_e           phase;
    logic [IDX_W-1:0] idx;

    rsg_loop_ctl #(.TRACE_LEN(TRACE_LEN)) u_ctl (
        .clk     (clk),
        .rst_n   (rst_n),
        .wrap_o  (wrap),
        .phase_o (phase),
        .idx_o   (idx)
    );

    rsg_addr_gen #(.S0(S0)) u_agen (
        .clk       (clk),
        .rst_n     (rst_n),
        .wrap_i    (wrap),
        .phase_i   (phase),
        .wr_addr_o (wr_addr_o),
        .rd_addr_o (rd_addr_o)
    );

    rsg_data_seq #(.DATA_SEED(DATA_SEED)) u_dseq (
        .clk    (clk),
        .rst_n  (rst_n),
        .wrap_i (wrap),
        .data_o (wr_data_o)
    );

    rsg_trace_chk #(.TRACE_LEN(TRACE_LEN)) u_chk (
        .clk       (clk),
        .rst_n     (rst_n),
        .idx_i     (idx),
        .phase_i   (phase),
        .rd_data_i (rd_data_i),
        .err_o     (err_o)
    );

    assign ref_phase_o = (phase == PH_REPLAY);

endmodule

// File: tb/raw_stress_top_bench.sv
module raw_stress_top_bench;

    localparam int          N     = 256;
    localparam logic [7:0]  S0    = 8'h5A;
    localparam logic [15:0] DSEED = 16'hACE1;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  wr_addr_o, rd_addr_o;
    logic [15:0] wr_data_o;
    logic        ref_phase_o;
    logic [15:0] rd_data_i;
    logic        err_o;

    raw_stress_top #(.TRACE_LEN(N), .S0(S0), .DATA_SEED(DSEED)) u_raw_stress_top (
        .clk(clk), .rst_n(rst_n), .wr_addr_o(wr_addr_o), .wr_data_o(wr_data_o),
        .rd_addr_o(rd_addr_o), .ref_phase_o(ref_phase_o), .rd_data_i(rd_data_i),
        .err_o(err_o)
    );

    always #5 clk = ~clk;

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [15:0] st16(input logic [15:0] s);
        return {s[14:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
    endfunction
    function automatic logic [7:0] st8(input logic [7:0] s);
        return {s[6:0], s[7] ^ s[5] ^ s[4] ^ s[3]};
    endfunction
    function automatic logic [15:0] std(input logic [15:0] s);
        return {s[14:0], s[15] ^ s[14] ^ s[12] ^ s[3]};
    endfunction

    // behavioural reference state
    logic [15:0] m_p, m_base, m_d;
    logic [7:0]  m_seed;
    int          m_cyc;
    bit          m_ph;
    bit          prev_vld, prev_ph, exp_err;
    int          prev_idx;
    logic [15:0] exp_trace [N];
    int          forced_cnt, replay_cnt;

    // memories: identical random starting contents
    logic [15:0] mut_mem [256];
    logic [15:0] ref_mem [256];
    logic [15:0] rd_q;
    bit          fault = 0;
    logic [7:0]  s_wa, s_ra;
    logic [15:0] s_wd;
    bit          s_ph;

    assign rd_data_i = rd_q;

    initial begin
        for (int i = 0; i < 256; i++) begin
            mut_mem[i] = 16'($urandom);
            ref_mem[i] = mut_mem[i];
        end
        rd_q = '0;
    end

    task automatic model_reset();
        m_p = {S0, S0}; m_base = {S0, S0}; m_seed = st8(S0);
        m_d = DSEED; m_cyc = 0; m_ph = 0;
        prev_vld = 0; exp_err = 0;
    endtask

    initial model_reset();

    always @(posedge clk) begin
        if (rst_n) begin
            if (s_ph) begin
                ref_mem[s_wa] = s_wd;
                rd_q <= ref_mem[s_ra];
            end else begin
                logic [15:0] old;
                old = mut_mem[s_ra];
                mut_mem[s_wa] = s_wd;
                rd_q <= (fault && s_ra == s_wa) ? old : mut_mem[s_ra];
            end
        end
    end

    always @(negedge clk) begin
        logic [7:0] e_wa, e_ra;
        e_wa = m_p[15:8];
        e_ra = (m_p[2:0] == 3'b101) ? e_wa : m_p[7:0];
        check(wr_addr_o == e_wa, "R1 wr_addr", int'(wr_addr_o), int'(e_wa));
        check(rd_addr_o == e_ra, "R1/R2 rd_addr", int'(rd_addr_o), int'(e_ra));
        check(wr_data_o == m_d, "R3 wr_data", int'(wr_data_o), int'(m_d));
        check(ref_phase_o == m_ph, "R4 phase", int'(ref_phase_o), int'(m_ph));
        check(err_o == exp_err, "R7/R8 err", int'(err_o), int'(exp_err));
        if (!rst_n) begin
            model_reset();
        end else begin
            if (m_p[2:0] == 3'b101) forced_cnt++;
            if (m_ph) replay_cnt++;
            // R6/R7 expected logging and comparison
            if (prev_vld) begin
                if (!prev_ph) exp_trace[prev_idx] = rd_data_i;
                else if (rd_data_i != exp_trace[prev_idx]) exp_err = 1;
            end
            prev_vld = 1; prev_ph = m_ph; prev_idx = m_cyc;
            s_wa = wr_addr_o; s_ra = rd_addr_o; s_wd = wr_data_o; s_ph = ref_phase_o;
            if (m_cyc == N - 1) begin
                m_cyc = 0;
                m_d = DSEED;
                if (!m_ph) m_p = m_base;
                else begin
                    m_p = {m_seed, m_seed};
                    m_base = m_p;
                    m_seed = st8(m_seed);
                end
                m_ph = ~m_ph;
            end else begin
                m_cyc++;
                m_p = st16(m_p);
                m_d = std(m_d);
            end
        end
    end

    task automatic do_reset();
        @(posedge clk); #1 rst_n = 0;
        repeat (3) @(posedge clk);
        @(negedge clk); #1;
        // R9 reset state
        check(ref_phase_o == 1'b0, "R9 phase in reset", int'(ref_phase_o), 0);
        check(wr_addr_o == S0, "R9 wr_addr in reset", int'(wr_addr_o), int'(S0));
        check(wr_data_o == DSEED, "R9 wr_data in reset", int'(wr_data_o), int'(DSEED));
        check(err_o == 1'b0, "R8/R9 err cleared by reset", int'(err_o), 0);
        @(posedge clk); #1 rst_n = 1;
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        summary();
    end

    initial begin
        forced_cnt = 0; replay_cnt = 0;
        do_reset();
        repeat (8 * N) @(posedge clk);
        @(negedge clk); #1;
        check(err_o == 1'b0, "R7 no error on matching memories", int'(err_o), 0);
        check(forced_cnt > 0, "R2 forced collisions occur", forced_cnt, 1);
        check(replay_cnt == 4 * N || replay_cnt == 4 * N - 1 || replay_cnt >= 3 * N,
              "R4 replay phases seen", replay_cnt, 4 * N);
        check(m_p != {S0, S0} || m_seed != st8(S0), "R5 reseed advanced", int'(m_seed), 0);

        // stale-on-collision memory under test
        fault = 1;
        do_reset();
        repeat (4 * N) @(posedge clk);
        @(negedge clk); #1;
        check(err_o == 1'b1, "R7 stale bypass flagged", int'(err_o), 1);
        check(exp_err == 1'b1, "R7 model saw mismatch", int'(exp_err), 1);

        fault = 0;
        repeat (2 * N) @(posedge clk);
        @(negedge clk); #1;
        check(err_o == 1'b1, "R8 error stays set", int'(err_o), 1);

        do_reset();
        repeat (4) @(posedge clk);
        @(negedge clk); #1;
        check(err_o == 1'b0, "R8 reset cleared error", int'(err_o), 0);
        summary();
    end

endmodule